// File: doc/BRIEF.md
# Flash Page Programming Sequencer

This block sits between a processor-style byte write port and a page-programmable nonvolatile array. A page-select bit in a control register diverts ordinary data writes into a one-page latch buffer of 128 bytes. While the bit is clear, the same writes are passed on as data-memory write enables. Every latch byte carries a valid flag, and the buffer also keeps the page number of the most recently latched byte.

Programming starts only after two back-to-back control writes that form a launch key. One key programs the user area, at addresses below 4000h. The other key programs the extra-row area, at addresses FF80h to FFFFh. While the copy runs, a busy flag stays high for a fixed number of clock cycles. When busy falls, every valid latch byte has been written into the array model and the valid flags have been cleared.

Reads of the array are combinational. Any byte that is erased, never written or outside the modelled range reads as FFh. The user area is modelled for `USER_PAGES` pages, which is a power of two and at least 2.

Top module: `flash_page_seq`

## Requirements
- R1: Bit 3 of a control write sets the page-select flag `psel`. The values 50h, 52h, A0h and A2h are key bytes and leave `psel` unchanged. With `psel`=1, a data write goes into the latch and `dmem_we` stays 0. With `psel`=0, `dmem_we` follows `wr_en`.
- R2: A latched write stores its byte at offset `wr_addr[6:0]`. A later latched write to the same offset replaces it.
- R3: The page that is programmed is `wr_addr[15:7]` of the most recent latched write.
- R4: The control write 50h followed directly by the control write A0h programs the user page. Pages at or beyond `USER_PAGES` are not stored.
- R5: The control write 52h followed directly by the control write A2h programs the extra-row page at FF80h to FFFFh. The user area is left unchanged.
- R6: The key is cancelled, nothing is programmed and `busy` stays 0 in these cases: a second byte that does not match the first, or any other control value written between the two key bytes.
- R7: `busy` rises on the clock edge that accepts the second key byte. It stays high for exactly `PROG_CYCLES` cycles. The array shows the new data once `busy` has fallen.
- R8: Only latch bytes loaded since the previous programming are written. Other array bytes keep their contents. All valid flags clear at the end of programming, so a repeated key with no new loads changes nothing.
- R9: While `busy` is high, latch loads and all control writes are ignored. This includes key bytes and changes to `psel`.
- R10: An unwritten byte reads FFh. So does any address that is neither in the modelled user pages nor in the extra row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data-space write strobe |
| wr_addr | input | 16 | Data-space write address |
| wr_data | input | 8 | Data-space write byte |
| dmem_we | output | 1 | Write enable forwarded to ordinary data memory |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write value |
| psel | output | 1 | Page-select flag (latch routing active) |
| busy | output | 1 | Programming in progress |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
A latch load and the acceptance of the second key byte can land in the same clock cycle. On that edge `busy` is still low, so the load is taken, and the copy then runs from the buffer as it stands after that edge. The bench provokes this by driving a data write to 0009h and the A0h control write on the same clock. It expects 0009h to read C3h once `busy` falls, and it expects the other bytes to keep the values they had before.

// File: rtl/flpg_pkg.sv
package flpg_pkg;
  localparam int PG_BYTES = 128;
  localparam int OFF_W    = 7;
  localparam int PG_W     = 16 - OFF_W;

  localparam logic [7:0] KEY_U1 = 8'h50;
  localparam logic [7:0] KEY_U2 = 8'hA0;
  localparam logic [7:0] KEY_X1 = 8'h52;
  localparam logic [7:0] KEY_X2 = 8'hA2;

  typedef enum logic [1:0] {ARM_NONE, ARM_USER, ARM_XROW} arm_t;

  function automatic logic is_key_byte(input logic [7:0] d);
    return (d == KEY_U1) || (d == KEY_U2) || (d == KEY_X1) || (d == KEY_X2);
  endfunction

  function automatic logic [PG_W-1:0] page_of(input logic [15:0] a);
    return a[15:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [15:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic in_xrow(input logic [15:0] a);
    return a[15:OFF_W] == {PG_W{1'b1}};
  endfunction

  function automatic arm_t next_arm(input logic [7:0] d);
    if (d == KEY_U1) return ARM_USER;
    if (d == KEY_X1) return ARM_XROW;
    return ARM_NONE;
  endfunction

  function automatic logic key_done(input arm_t cur, input logic [7:0] d);
    return ((cur == ARM_USER) && (d == KEY_U2)) || ((cur == ARM_XROW) && (d == KEY_X2));
  endfunction
endpackage

// File: rtl/flpg_keyctl.sv
module flpg_keyctl
  import flpg_pkg::*;
#(
  parameter int PROG_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  output logic       psel,
  output logic       busy,
  output logic       tgt_xrow,
  output logic       prog_done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  arm_t             arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ctl_ok;
  logic             launch;

  assign ctl_ok    = ctl_wr && !busy;
  assign launch    = ctl_ok && key_done(arm_q, ctl_data);
  assign prog_done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= ARM_NONE;
      psel     <= 1'b0;
      busy     <= 1'b0;
      tgt_xrow <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (ctl_ok) begin
        arm_q <= next_arm(ctl_data);
        if (!is_key_byte(ctl_data)) psel <= ctl_data[3];
      end
      if (launch) begin
        busy     <= 1'b1;
        tgt_xrow <= (arm_q == ARM_XROW);
        cnt_q    <= CNT_W'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // checker-side run length of the busy window
  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < CNT_W'(PROG_CYCLES)));
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy);
  a_r6_rise_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctl_wr) && (($past(ctl_data) == KEY_U2) || ($past(ctl_data) == KEY_X2))));
  a_r9_psel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> $stable(psel));
endmodule

// File: rtl/flpg_latch.sv
module flpg_latch
  import flpg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [15:0]                   ld_addr,
  input  logic [7:0]                    ld_data,
  input  logic                          clr,
  output logic [PG_BYTES-1:0][7:0]      lat_data,
  output logic [PG_BYTES-1:0]           lat_valid,
  output logic [PG_W-1:0]               last_page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_data  <= '0;
      lat_valid <= '0;
      last_page <= '0;
    end else if (clr) begin
      lat_valid <= '0;
    end else if (ld_en) begin
      lat_data[off_of(ld_addr)]  <= ld_data;
      lat_valid[off_of(ld_addr)] <= 1'b1;
      last_page                  <= page_of(ld_addr);
    end
  end

  a_r8_valid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat_valid == '0));
  a_r2_load_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clr) |=> (lat_valid != '0));
endmodule

// File: rtl/flpg_array.sv
module flpg_array
  import flpg_pkg::*;
#(
  parameter int USER_PAGES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     xrow,
  input  logic [PG_W-1:0]          page,
  input  logic [PG_BYTES-1:0][7:0] src_data,
  input  logic [PG_BYTES-1:0]      src_valid,
  input  logic [15:0]              rd_addr,
  output logic [7:0]               rd_data
);
  localparam int UP_W    = $clog2(USER_PAGES);
  localparam int U_BYTES = USER_PAGES * PG_BYTES;
  localparam int UA_W    = UP_W + OFF_W;
  localparam logic [15:0]     U_LIMIT  = 16'(U_BYTES);
  localparam logic [PG_W-1:0] UP_LIMIT = PG_W'(USER_PAGES);

  logic [7:0] u_mem  [U_BYTES];
  logic [7:0] xr_mem [PG_BYTES];
  logic       user_hit;

  assign user_hit = !xrow && (page < UP_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < U_BYTES; i++) u_mem[i] <= 8'hFF;
      for (int i = 0; i < PG_BYTES; i++) xr_mem[i] <= 8'hFF;
    end else if (wr) begin
      for (int i = 0; i < PG_BYTES; i++) begin
        if (src_valid[i]) begin
          if (xrow) xr_mem[i] <= src_data[i];
          else if (user_hit) u_mem[{page[UP_W-1:0], OFF_W'(i)}] <= src_data[i];
        end
      end
    end
  end

  always_comb begin
    if (in_xrow(rd_addr)) rd_data = xr_mem[off_of(rd_addr)];
    else if (rd_addr < U_LIMIT) rd_data = u_mem[rd_addr[UA_W-1:0]];
    else rd_data = 8'hFF;
  end
endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import flpg_pkg::*;
#(
  parameter int USER_PAGES  = 4,
  parameter int PROG_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        dmem_we,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_data,
  output logic        psel,
  output logic        busy,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data
);
  logic                     lat_we;
  logic                     prog_done;
  logic                     tgt_xrow;
  logic [PG_BYTES-1:0][7:0] lat_data;
  logic [PG_BYTES-1:0]      lat_valid;
  logic [PG_W-1:0]          last_page;

  assign lat_we  = wr_en && psel && !busy;
  assign dmem_we = wr_en && !psel;

  flpg_keyctl #(.PROG_CYCLES(PROG_CYCLES)) u_key (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .psel(psel), .busy(busy), .tgt_xrow(tgt_xrow), .prog_done(prog_done)
  );

  flpg_latch u_lat (
    .clk(clk), .rst_n(rst_n), .ld_en(lat_we), .ld_addr(wr_addr), .ld_data(wr_data),
    .clr(prog_done), .lat_data(lat_data), .lat_valid(lat_valid), .last_page(last_page)
  );

  flpg_array #(.USER_PAGES(USER_PAGES)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr(prog_done), .xrow(tgt_xrow), .page(last_page),
    .src_data(lat_data), .src_valid(lat_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> $stable(lat_valid));
  a_r3_page_tracks_load: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> (last_page == $past(wr_addr[15:7])));
endmodule

// File: tb/flash_page_seq_tb.sv
module flash_page_seq_tb;
  localparam int PROG_CYCLES = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        dmem_we;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic        psel;
  logic        busy;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  flash_page_seq #(.USER_PAGES(4), .PROG_CYCLES(PROG_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dmem_we(dmem_we), .ctl_wr(ctl_wr), .ctl_data(ctl_data), .psel(psel), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: queue an expected read, monitor compares
  task automatic expect_rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(rd_data == it.exp, it.tag, int'(rd_data), int'(it.exp));
      end
    end
  end

  task automatic ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic we_seen);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 we_seen = dmem_we;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : stim
    logic we;
    int   n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R7 reset busy", busy, 0);
    chk(psel == 1'b0, "R1 reset psel", psel, 0);
    expect_rd(16'h0000, 8'hFF, "R10 erased");

    // R1 routing
    wr(16'h0040, 8'hAA, we);
    chk(we == 1'b1, "R1 dmem with psel=0", we, 1);
    ctl(8'h08);
    chk(psel == 1'b1, "R1 psel set", psel, 1);
    wr(16'h0085, 8'h11, we);
    chk(we == 1'b0, "R1 latch write no dmem", we, 0);
    wr(16'h0086, 8'h22, we);
    wr(16'h0107, 8'h33, we);
    wr(16'h0105, 8'h44, we);   // R2 overwrite of offset 5, R3 last page 2
    ctl(8'h50);
    chk(psel == 1'b1, "R1 key byte keeps psel", psel, 1);
    ctl(8'hA0);
    chk(busy == 1'b1, "R4 busy after key", busy, 1);
    // R9 stimulus while busy
    wr(16'h0110, 8'h99, we);
    ctl(8'h00);
    ctl(8'h52);
    ctl(8'hA2);
    wait_idle(n);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 key ignored while busy", busy, 0);
    chk(psel == 1'b1, "R9 ctl ignored while busy", psel, 1);
    expect_rd(16'h0105, 8'h44, "R2 overwrite");
    expect_rd(16'h0106, 8'h22, "R3 page");
    expect_rd(16'h0107, 8'h33, "R4 user program");
    expect_rd(16'h0085, 8'hFF, "R3 earlier page unused");
    expect_rd(16'h0104, 8'hFF, "R8 unloaded byte");
    expect_rd(16'hFF85, 8'hFF, "R5 xrow untouched by user key");

    // R6 broken keys
    wr(16'h0180, 8'h5A, we);
    ctl(8'h50); ctl(8'h55);
    @(negedge clk);
    chk(busy == 1'b0, "R6 wrong second byte", busy, 0);
    ctl(8'h08);
    ctl(8'h50); ctl(8'hA2);
    @(negedge clk);
    chk(busy == 1'b0, "R6 mismatched pair", busy, 0);
    ctl(8'h50); ctl(8'h08); ctl(8'hA0);
    @(negedge clk);
    chk(busy == 1'b0, "R6 interrupted key", busy, 0);
    expect_rd(16'h0180, 8'hFF, "R6 nothing programmed");

    // R5 extra row, R7 busy length
    ctl(8'h52); ctl(8'hA2);
    wait_idle(n);
    chk(n == PROG_CYCLES, "R7 busy length", n, PROG_CYCLES);
    expect_rd(16'hFF80, 8'h5A, "R5 xrow programmed");
    expect_rd(16'h0180, 8'hFF, "R5 user area unchanged");

    // R8 partial page and empty reprogram
    wr(16'h0106, 8'h77, we);
    ctl(8'h50); ctl(8'hA0);
    wait_idle(n);
    expect_rd(16'h0106, 8'h77, "R8 loaded byte");
    expect_rd(16'h0105, 8'h44, "R8 old byte kept");
    expect_rd(16'h0110, 8'hFF, "R9 busy load dropped");
    ctl(8'h50); ctl(8'hA0);
    wait_idle(n);
    chk(n == PROG_CYCLES, "R7 busy length empty page", n, PROG_CYCLES);
    expect_rd(16'h0106, 8'h77, "R8 empty reprogram");
    expect_rd(16'hFF80, 8'h5A, "R8 xrow kept");

    // same-cycle latch load and key completion
    ctl(8'h50);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = 8'hA0;
    wr_en = 1'b1; wr_addr = 16'h0009; wr_data = 8'hC3;
    @(negedge clk);
    ctl_wr = 1'b0; wr_en = 1'b0;
    wait_idle(n);
    expect_rd(16'h0009, 8'hC3, "R7 same-cycle load included");
    expect_rd(16'h0106, 8'h77, "R8 same-cycle others kept");

    // R10 unmapped
    expect_rd(16'h3FFF, 8'hFF, "R10 beyond model");
    expect_rd(16'h4000, 8'hFF, "R10 above user area");
    expect_rd(16'hFF81, 8'hFF, "R10 unwritten xrow");

    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule